// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

This block is one general-purpose I/O port of parameterised width (eight pins by default) reached through a plain register bus. The bus has an address, write data, a write strobe, a read strobe and a registered read data output. Software sets each pin's direction and its polarity. It writes the output value. It chooses per pin whether a written one is held as a level or sent out as a single pulse of fixed length. Each pin is open-drain, so it is modelled as an output enable and a value.

Two read-only registers give the pin state back. The first shows the live pins after a two-flop synchronizer, with polarity applied. The second holds a snapshot of the raw pins taken just after power-on reset. That snapshot can also be retaken while the external reset pin is low.

The external reset pin can return the writable registers to their reset values. Whether it does so is chosen by an input. Other functions that share the pins take them over through per-pin override inputs. Every bus, reset and configuration pin is a plain control signal. There is no streaming interface and no back-pressure.

Top module: `gpio_port`

## Requirements
- R1: After power-on reset the direction register reads 0xFF, polarity reads 0xF0, output data reads 0x00 and style reads 0x00. Every pin_oe bit is 0.
- R2: A direction bit of 1 makes the pin an input and its pin_oe bit is 0, whatever the output data holds. A direction bit of 0 makes the pin an output and its pin_oe bit is 1.
- R3: For an output pin in level mode (style bit 0), pin_out equals the output data bit XOR the polarity bit.
- R4: The live input register reads each pin through a two-flop synchronizer, XOR the polarity bit. A pin change applied before a clock edge is visible to a read strobe issued two edges later.
- R5: For a pin in pulse mode (style bit 1), writing 1 to its output data bit drives pin_out to the active level (NOT polarity) for exactly PULSE_CYCLES clocks, starting at the write edge. The stored bit then clears itself and reads back as 0. Writing 1 again on the edge where a pulse would end keeps the pin active for a further PULSE_CYCLES clocks without a gap.
- R6: Reading the output data register returns the stored flip-flop value, not the pin level.
- R7: The snapshot register captures the raw pin_in value on the first clock after power-on reset is released. When cfg_snap_on_ext is 1 it also captures on every clock while ext_rst_n is low. Otherwise it holds its value.
- R8: When cfg_ext_clears_regs is 1, a clock edge with ext_rst_n low returns output data, polarity, direction and style to their R1 values. When it is 0, ext_rst_n leaves them unchanged.
- R9: Address map: 0 live input, 1 snapshot, 2 output data, 3 polarity, 4 direction, 5 style. reg_rdata loads the addressed register on a clock edge with reg_re high and holds otherwise. Addresses 6 and 7 read as 0.
- R10: Writes to address 0 or 1 change no register.
- R11: An ovr_en bit of 1 forces that pin's pin_oe to 1 and its pin_out to the matching ovr_val bit, whatever the direction, data, polarity and style registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset pin, sampled on clk, active low |
| cfg_snap_on_ext | input | 1 | 1: snapshot also captures while ext_rst_n is low |
| cfg_ext_clears_regs | input | 1 | 1: ext_rst_n returns the writable registers to defaults |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | WIDTH | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Pin levels |
| pin_oe | output | WIDTH | Per-pin output enable |
| pin_out | output | WIDTH | Per-pin driven value |
| ovr_en | input | WIDTH | Per-pin override enable from a shared function |
| ovr_val | input | WIDTH | Per-pin override value |

## Verification
Two functions of this block can act in the same clock edge.

The first pair is a running pulse reaching its last cycle and a fresh write of 1 to the same bit. The bench issues the second write exactly PULSE_CYCLES edges after the first. It then counts the active samples of the pin and expects an unbroken run of twice PULSE_CYCLES.

The second pair is an external reset and the register state it may or may not clear. The bench pulls ext_rst_n low with each setting of the two configuration inputs. It then reads back the snapshot and the writable registers to judge which one won.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  localparam int ADDR_W   = 3;
  localparam int NUM_REGS = 6;
  localparam logic [ADDR_W-1:0] ADDR_LIVE  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SNAP  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_OUT   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_POL   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DIR   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_STYLE = 3'd5;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pulse_lane.sv
`timescale 1ns/1ps
module gpio_pulse_lane #(
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic pulse_mode,
  input  logic wr,
  input  logic wbit,
  output logic q
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      q     <= 1'b0;
      cnt_q <= '0;
    end else if (clr) begin
      q     <= 1'b0;
      cnt_q <= '0;
    end else if (wr) begin
      q     <= wbit;
      cnt_q <= (pulse_mode && wbit) ? CNT_LOAD : '0;
    end else if (pulse_mode) begin
      if (cnt_q > CNT_ONE) begin
        cnt_q <= cnt_q - CNT_ONE;
      end else begin
        cnt_q <= '0;
        q     <= 1'b0;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/gpio_snapshot.sv
`timescale 1ns/1ps
module gpio_snapshot #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_low,
  input  logic             snap_on_ext,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] snap_q,
  output logic             capturing
);
  logic first_q;

  assign capturing = first_q | (ext_low & snap_on_ext);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      first_q <= 1'b1;
      snap_q  <= '0;
    end else begin
      first_q <= 1'b0;
      if (capturing) snap_q <= pin_raw;
    end
  end
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter int               PULSE_CYCLES = 4,
  parameter logic [WIDTH-1:0] POL_RESET    = 8'hF0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              cfg_snap_on_ext,
  input  logic              cfg_ext_clears_regs,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WIDTH-1:0]  reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [WIDTH-1:0]  reg_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_out,
  input  logic [WIDTH-1:0]  ovr_en,
  input  logic [WIDTH-1:0]  ovr_val
);
  logic [WIDTH-1:0] dir_q, pol_q, style_q, out_q;
  logic [WIDTH-1:0] pin_sync, snap_q, rd_mux;
  logic             ext_hit, snap_cap;
  logic             we_out, we_pol, we_dir, we_style;

  assign ext_hit  = !ext_rst_n && cfg_ext_clears_regs;
  assign we_out   = reg_we && (reg_addr == ADDR_OUT);
  assign we_pol   = reg_we && (reg_addr == ADDR_POL);
  assign we_dir   = reg_we && (reg_addr == ADDR_DIR);
  assign we_style = reg_we && (reg_addr == ADDR_STYLE);

  // configuration registers
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pol_q   <= POL_RESET;
      dir_q   <= '1;
      style_q <= '0;
    end else if (ext_hit) begin
      pol_q   <= POL_RESET;
      dir_q   <= '1;
      style_q <= '0;
    end else begin
      if (we_pol)   pol_q   <= reg_wdata;
      if (we_dir)   dir_q   <= reg_wdata;
      if (we_style) style_q <= reg_wdata;
    end
  end

  // per-pin output data with level or pulse behaviour
  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    gpio_pulse_lane #(.PULSE_CYCLES(PULSE_CYCLES)) u_lane (
      .clk        (clk),
      .por_n      (por_n),
      .clr        (ext_hit),
      .pulse_mode (style_q[i]),
      .wr         (we_out),
      .wbit       (reg_wdata[i]),
      .q          (out_q[i])
    );
  end

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  gpio_snapshot #(.WIDTH(WIDTH)) u_snap (
    .clk         (clk),
    .por_n       (por_n),
    .ext_low     (!ext_rst_n),
    .snap_on_ext (cfg_snap_on_ext),
    .pin_raw     (pin_in),
    .snap_q      (snap_q),
    .capturing   (snap_cap)
  );

  // pin drive: override first, then direction
  always_comb begin
    pin_oe  = ovr_en | ~dir_q;
    pin_out = (ovr_en & ovr_val) | (~ovr_en & (out_q ^ pol_q));
  end

  // read path
  always_comb begin
    case (reg_addr)
      ADDR_LIVE:  rd_mux = pin_sync ^ pol_q;
      ADDR_SNAP:  rd_mux = snap_q;
      ADDR_OUT:   rd_mux = out_q;
      ADDR_POL:   rd_mux = pol_q;
      ADDR_DIR:   rd_mux = dir_q;
      ADDR_STYLE: rd_mux = style_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter int               PULSE_CYCLES = 4,
  parameter logic [WIDTH-1:0] POL_RESET    = 8'hF0
) (
  input logic              clk,
  input logic              por_n,
  input logic              ext_rst_n,
  input logic              cfg_ext_clears_regs,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic              reg_re,
  input logic [WIDTH-1:0]  reg_rdata,
  input logic [WIDTH-1:0]  pin_oe,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  ovr_en,
  input logic [WIDTH-1:0]  ovr_val,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  pol_q,
  input logic [WIDTH-1:0]  style_q,
  input logic [WIDTH-1:0]  out_q,
  input logic [WIDTH-1:0]  snap_q,
  input logic              snap_cap
);
  localparam int RUN_W = $clog2(PULSE_CYCLES + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PULSE_CYCLES);

  // R2: an input pin that is not overridden never drives
  a_r2_input_no_drive: assert property (@(posedge clk) disable iff (!por_n)
    (pin_oe & dir_q & ~ovr_en) == '0);

  // R11: override controls the pin completely
  a_r11_override: assert property (@(posedge clk) disable iff (!por_n)
    ((ovr_en & ~pin_oe) == '0) && ((ovr_en & (pin_out ^ ovr_val)) == '0));

  // R8: external reset with clearing enabled restores defaults
  a_r8_ext_defaults: assert property (@(posedge clk) disable iff (!por_n)
    (!ext_rst_n && cfg_ext_clears_regs) |=>
      (dir_q == '1) && (pol_q == POL_RESET) && (style_q == '0) && (out_q == '0));

  // R9: unmapped addresses read as zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!por_n)
    (reg_re && (int'(reg_addr) >= NUM_REGS)) |=> (reg_rdata == '0));

  // R9: read data holds without a read strobe
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!por_n)
    !reg_re |=> $stable(reg_rdata));

  // R10: writes to read-only addresses leave configuration untouched
  a_r10_ro_write: assert property (@(posedge clk) disable iff (!por_n)
    (reg_we && ext_rst_n && (reg_addr == ADDR_LIVE || reg_addr == ADDR_SNAP)) |=>
      ($stable(dir_q) && $stable(pol_q) && $stable(style_q)));

  // R7: snapshot only changes in a capture cycle
  a_r7_snap_hold: assert property (@(posedge clk) disable iff (!por_n)
    !snap_cap |=> $stable(snap_q));

  // R5: a pulse-mode bit never stays set longer than PULSE_CYCLES
  for (genvar i = 0; i < WIDTH; i++) begin : g_run
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                          run_q <= '0;
      else if (style_q[i] && out_q[i] && !(reg_we && reg_addr == ADDR_OUT))
        run_q <= (run_q < RUN_MAX + RUN_W'(1)) ? run_q + RUN_W'(1) : run_q;
      else                                 run_q <= '0;
    end
    a_r5_pulse_len: assert property (@(posedge clk) disable iff (!por_n)
      run_q <= RUN_MAX);
  end
endmodule

bind gpio_port gpio_port_chk #(
  .WIDTH(WIDTH), .PULSE_CYCLES(PULSE_CYCLES), .POL_RESET(POL_RESET)
) u_chk (
  .clk                 (clk),
  .por_n               (por_n),
  .ext_rst_n           (ext_rst_n),
  .cfg_ext_clears_regs (cfg_ext_clears_regs),
  .reg_addr            (reg_addr),
  .reg_we              (reg_we),
  .reg_re              (reg_re),
  .reg_rdata           (reg_rdata),
  .pin_oe              (pin_oe),
  .pin_out             (pin_out),
  .ovr_en              (ovr_en),
  .ovr_val             (ovr_val),
  .dir_q               (dir_q),
  .pol_q               (pol_q),
  .style_q             (style_q),
  .out_q               (out_q),
  .snap_q              (snap_q),
  .snap_cap            (snap_cap)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  localparam int W = 8;
  localparam int P = 4;

  logic         clk = 1'b0;
  logic         por_n, ext_rst_n, cfg_snap_on_ext, cfg_ext_clears_regs;
  logic [2:0]   reg_addr;
  logic [W-1:0] reg_wdata, reg_rdata, pin_in, pin_oe, pin_out, ovr_en, ovr_val;
  logic         reg_we, reg_re;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_port #(.WIDTH(W), .PULSE_CYCLES(P), .POL_RESET(8'hF0)) dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .cfg_snap_on_ext(cfg_snap_on_ext), .cfg_ext_clears_regs(cfg_ext_clears_regs),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .ovr_en(ovr_en), .ovr_val(ovr_val)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    reg_addr = a; reg_re = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic ext_pulse(input int n);
    ext_rst_n = 1'b0;
    repeat (n) @(negedge clk);
    ext_rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd(3'd4, v); check("R1 dir", v, 8'hFF);
    rd(3'd3, v); check("R1 pol", v, 8'hF0);
    rd(3'd2, v); check("R1 out", v, 8'h00);
    rd(3'd5, v); check("R1 style", v, 8'h00);
    check("R1 oe", pin_oe, 8'h00);
    rd(3'd1, v); check("R7 snapshot at power-on", v, 8'h96);
  endtask

  task automatic t_input();
    logic [W-1:0] v;
    pin_in = 8'h3C;
    @(negedge clk); @(negedge clk);
    rd(3'd0, v); check("R4 live input xor pol", v, 8'hCC);
    pin_in = 8'hFF;
    @(negedge clk); @(negedge clk);
    rd(3'd0, v); check("R4 live input all ones", v, 8'h0F);
  endtask

  task automatic t_readback();
    logic [W-1:0] v;
    pin_in = 8'h00;
    wr(3'd2, 8'hA5);
    rd(3'd2, v); check("R6 out readback", v, 8'hA5);
    check("R2 input pins not driven", pin_oe, 8'h00);
  endtask

  task automatic t_level();
    wr(3'd4, 8'h00);
    check("R2 output pins driven", pin_oe, 8'hFF);
    check("R3 level out pol F0", pin_out, 8'h55);
    wr(3'd3, 8'h0F);
    check("R3 level out pol 0F", pin_out, 8'hAA);
    wr(3'd2, 8'h00);
    check("R3 level out zero data", pin_out, 8'h0F);
    wr(3'd4, 8'hF0);
    check("R2 mixed direction", pin_oe, 8'h0F);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_pulse();
    logic [W-1:0] v;
    int n;
    wr(3'd5, 8'h11);
    wr(3'd2, 8'h11);
    check("R5 pulse active levels", pin_out, 8'h1E);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      if (pin_out[4]) begin n++; @(negedge clk); end
    end
    check("R5 pulse length", n, P);
    check("R5 idle level after pulse", pin_out, 8'h0F);
    rd(3'd2, v); check("R5 self clear", v, 8'h00);
  endtask

  task automatic t_pulse_restart();
    int n;
    n = 0;
    wr(3'd2, 8'h10);
    for (int k = 0; k < P; k++) begin
      if (pin_out[4]) n++;
      if (k < P - 1) @(negedge clk);
    end
    wr(3'd2, 8'h10);
    for (int k = 0; k < 20; k++) begin
      if (pin_out[4]) begin n++; @(negedge clk); end
    end
    check("R5 restart on final edge", n, 2 * P);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_override();
    wr(3'd4, 8'hFF);
    ovr_en = 8'h81; ovr_val = 8'h01;
    #1;
    check("R11 override oe", pin_oe, 8'h81);
    check("R11 override value", pin_out & 8'h81, 8'h01);
    ovr_en = 8'h00; ovr_val = 8'h00;
    #1;
    check("R11 override released", pin_oe, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [W-1:0] v;
    rd(3'd6, v); check("R9 addr 6 zero", v, 8'h00);
    rd(3'd7, v); check("R9 addr 7 zero", v, 8'h00);
    rd(3'd3, v); check("R9 pol read", v, 8'h0F);
    reg_addr = 3'd6;
    @(negedge clk); @(negedge clk);
    check("R9 rdata holds", reg_rdata, 8'h0F);
  endtask

  task automatic t_readonly();
    logic [W-1:0] v;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    rd(3'd1, v); check("R10 snapshot untouched", v, 8'h96);
    rd(3'd4, v); check("R10 dir untouched", v, 8'hFF);
    rd(3'd3, v); check("R10 pol untouched", v, 8'h0F);
  endtask

  task automatic t_snapshot();
    logic [W-1:0] v;
    cfg_ext_clears_regs = 1'b0;
    cfg_snap_on_ext = 1'b0;
    pin_in = 8'h11;
    ext_pulse(2);
    rd(3'd1, v); check("R7 no capture when disabled", v, 8'h96);
    rd(3'd3, v); check("R8 regs kept when not enabled", v, 8'h0F);
    cfg_snap_on_ext = 1'b1;
    ext_pulse(2);
    rd(3'd1, v); check("R7 capture during ext reset", v, 8'h11);
    pin_in = 8'h22;
    @(negedge clk); @(negedge clk);
    rd(3'd1, v); check("R7 snapshot holds", v, 8'h11);
    cfg_snap_on_ext = 1'b0;
  endtask

  task automatic t_ext_regs();
    logic [W-1:0] v;
    wr(3'd4, 8'h3C);
    wr(3'd5, 8'h02);
    wr(3'd2, 8'h40);
    cfg_ext_clears_regs = 1'b1;
    ext_pulse(1);
    cfg_ext_clears_regs = 1'b0;
    rd(3'd4, v); check("R8 dir default", v, 8'hFF);
    rd(3'd3, v); check("R8 pol default", v, 8'hF0);
    rd(3'd2, v); check("R8 out default", v, 8'h00);
    rd(3'd5, v); check("R8 style default", v, 8'h00);
    check("R8 oe after ext reset", pin_oe, 8'h00);
  endtask

  initial begin
    por_n = 1'b0; ext_rst_n = 1'b1;
    cfg_snap_on_ext = 1'b0; cfg_ext_clears_regs = 1'b0;
    reg_addr = '0; reg_wdata = '0; reg_we = 1'b0; reg_re = 1'b0;
    pin_in = 8'h96; ovr_en = '0; ovr_val = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk); @(negedge clk);
    t_reset();
    t_input();
    t_readback();
    t_level();
    t_pulse();
    t_pulse_restart();
    t_override();
    t_unmapped();
    t_readonly();
    t_snapshot();
    t_ext_regs();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule